// File: doc/BRIEF.md
# Page-Load Write Buffer Controller

The block gathers host word writes into a one-page staging buffer and then commits that page to a backing array. A write is taken when the synchronous host bus has chip-select and write-enable high and output-enable low. The first accepted write fixes the page address (address bits 15..7). The writes that follow may target the words of that page (bits 6..0) in any order. A write whose page address differs from the fixed page is discarded.

Loading ends when no accepted write has arrived for a parameterised number of clock cycles. A self-timed program cycle of fixed length then runs. In its final cycle the whole page is presented at once on a wide array write port, and any word that was never loaded is driven as all ones. Writes are refused until a power-on delay has passed since reset, and they are also refused while programming runs. The busy flag covers the whole span from the first accepted write to the end of programming.

Top module: `page_load_ctrl`

## Requirements
- R1: An accepted word is committed at word index addr_i[6:0] of the page addr_i[15:7]; arr_page_o carries the page and word i of arr_data_o is bits [16*i+15:16*i].
- R2: Words of a page may be loaded in any order; each committed word equals the data last loaded at its index.
- R3: Each accepted same-page write restarts the load window, and programming begins LOAD_WIN cycles after the last accepted write.
- R4: Every word not loaded during the current load is committed as 16'hFFFF.
- R5: The program cycle lasts PROG_CYC cycles. arr_we_o is high for exactly one cycle, the last one. busy_o falls LOAD_WIN+PROG_CYC rising edges after the edge that sampled the last accepted write.
- R6: A write is accepted only when cs_i=1, we_i=1 and oe_i=0. oe_i=1, cs_i=0 or we_i=0 each blocks it.
- R7: No write is accepted during the first PWRUP_CYC rising edges after reset is released.
- R8: A write to a page other than the one fixed by the first accepted write is ignored and does not restart the load window.
- R9: Writes that arrive during the program cycle are ignored.
- R10: busy_o is low out of reset, rises on the edge after the first accepted write, and stays high until programming completes.
- R11: The loaded-word mask is cleared at the end of each program cycle, so a later load starts with every word at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write enable, active high |
| oe_i | input | 1 | Output enable, active high; blocks writes |
| addr_i | input | 16 | Word address: [15:7] page, [6:0] word |
| data_i | input | 16 | Write data |
| busy_o | output | 1 | Load or program in progress |
| arr_we_o | output | 1 | One-cycle array commit strobe |
| arr_page_o | output | 9 | Page being committed |
| arr_data_o | output | 2048 | Full page image, word i at [16*i+15:16*i] |

## Verification
The hardest situations to reach are writes that land inside the long busy interval: a foreign-page write placed in the middle of the load window, and writes sent after the window has expired but before the commit. The bench gets there by counting edges from the last accepted write, so that it can place such a write in a known phase. It then checks that the total busy length stays at LOAD_WIN+PROG_CYC and that the committed image does not contain the stray data. A second load of the same page, with fewer words than the first, shows that the old mask does not carry over.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_cnt.sv
module plc_cnt #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= RST_VAL;
    else if (load_i)                cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
  parameter int unsigned PAGE_AW = 7,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned NWORDS = 1 << PAGE_AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_i,
  input  logic [PAGE_AW-1:0]       idx_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     clr_i,
  output logic [NWORDS*DATA_W-1:0] page_o
);
  logic [DATA_W-1:0] mem_q [NWORDS];
  logic [NWORDS-1:0] mask_q;

  always_ff @(posedge clk_i) begin
    if (ld_i) mem_q[idx_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (ld_i)  mask_q[idx_i] <= 1'b1;
  end

  // unloaded words read back as erased
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign page_o[g*DATA_W +: DATA_W] = mask_q[g] ? mem_q[g] : {DATA_W{1'b1}};
  end

  assert_mask_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_q == '0));
  assert_no_load_at_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !ld_i);
endmodule

// File: rtl/plc_seq.sv
module plc_seq
  import plc_pkg::*;
#(
  parameter int unsigned PG_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_req_i,
  input  logic            ready_i,
  input  logic [PG_W-1:0] pg_i,
  input  logic            win_zero_i,
  input  logic            prog_zero_i,
  output logic            ld_o,
  output logic            win_load_o,
  output logic            win_dec_o,
  output logic            prog_load_o,
  output logic            prog_dec_o,
  output logic            commit_o,
  output logic            busy_o,
  output logic [PG_W-1:0] page_o
);
  plc_state_e state_q, state_d;
  logic [PG_W-1:0] page_q;
  logic accept;

  assign accept = wr_req_i && ready_i;

  always_comb begin
    state_d     = state_q;
    ld_o        = 1'b0;
    win_load_o  = 1'b0;
    prog_load_o = 1'b0;
    commit_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        ld_o       = 1'b1;
        win_load_o = 1'b1;
        state_d    = ST_LOAD;
      end
      ST_LOAD: if (accept && pg_i == page_q) begin
        ld_o       = 1'b1;
        win_load_o = 1'b1;
      end else if (win_zero_i) begin
        prog_load_o = 1'b1;
        state_d     = ST_PROG;
      end
      ST_PROG: if (prog_zero_i) begin
        commit_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign win_dec_o  = (state_q == ST_LOAD);
  assign prog_dec_o = (state_q == ST_PROG);
  assign busy_o     = (state_q != ST_IDLE);
  assign page_o     = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && accept) page_q <= pg_i;
    end
  end

  assert_busy_ends_on_commit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(commit_o));
  assert_busy_starts_on_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(ld_o));
  assert_commit_then_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o);
  assert_page_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(page_q));
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_AW   = 7,
  parameter int unsigned LOAD_WIN  = 30000,
  parameter int unsigned PROG_CYC  = 1000000,
  parameter int unsigned PWRUP_CYC = 1000000,
  localparam int unsigned NWORDS   = 1 << PAGE_AW,
  localparam int unsigned PG_W     = ADDR_W - PAGE_AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_i,
  input  logic                     we_i,
  input  logic                     oe_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic                     busy_o,
  output logic                     arr_we_o,
  output logic [PG_W-1:0]          arr_page_o,
  output logic [NWORDS*DATA_W-1:0] arr_data_o
);
  localparam int unsigned WIN_W = $clog2(LOAD_WIN + 1);
  localparam int unsigned PRG_W = $clog2(PROG_CYC + 1);
  localparam int unsigned PWR_W = $clog2(PWRUP_CYC + 1);

  logic wr_req, pwr_ready, win_zero, prog_zero;
  logic ld, win_load, win_dec, prog_load, prog_dec, commit;

  assign wr_req = cs_i && we_i && !oe_i;

  plc_cnt #(.W(PWR_W), .RST_VAL(PWR_W'(PWRUP_CYC))) u_pwr (
    .clk_i, .rst_ni, .load_i(1'b0), .val_i('0), .dec_i(1'b1), .zero_o(pwr_ready));

  plc_cnt #(.W(WIN_W)) u_win (
    .clk_i, .rst_ni, .load_i(win_load), .val_i(WIN_W'(LOAD_WIN - 1)),
    .dec_i(win_dec), .zero_o(win_zero));

  plc_cnt #(.W(PRG_W)) u_prog (
    .clk_i, .rst_ni, .load_i(prog_load), .val_i(PRG_W'(PROG_CYC - 1)),
    .dec_i(prog_dec), .zero_o(prog_zero));

  plc_seq #(.PG_W(PG_W)) u_seq (
    .clk_i, .rst_ni, .wr_req_i(wr_req), .ready_i(pwr_ready),
    .pg_i(addr_i[ADDR_W-1:PAGE_AW]), .win_zero_i(win_zero), .prog_zero_i(prog_zero),
    .ld_o(ld), .win_load_o(win_load), .win_dec_o(win_dec),
    .prog_load_o(prog_load), .prog_dec_o(prog_dec), .commit_o(commit),
    .busy_o(busy_o), .page_o(arr_page_o));

  plc_page_buf #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .ld_i(ld), .idx_i(addr_i[PAGE_AW-1:0]), .data_i(data_i),
    .clr_i(commit), .page_o(arr_data_o));

  assign arr_we_o = commit;

  assert_pwrup_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ready |-> !busy_o);
  assert_commit_only_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);
endmodule

// File: tb/sim_page_load_ctrl.sv
module sim_page_load_ctrl;
  localparam int W = 12;
  localparam int P = 25;
  localparam int U = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0, oe = 0;
  logic [15:0] addr = '0, data = '0;
  logic busy, arr_we;
  logic [8:0] arr_page;
  logic [2047:0] arr_data;

  logic [8:0]    cap_page;
  logic [2047:0] cap_data;
  int commits = 0;
  int errors = 0, checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  page_load_ctrl #(.LOAD_WIN(W), .PROG_CYC(P), .PWRUP_CYC(U)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .oe_i(oe),
    .addr_i(addr), .data_i(data), .busy_o(busy), .arr_we_o(arr_we),
    .arr_page_o(arr_page), .arr_data_o(arr_data));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_we) begin
      cap_page <= arr_page;
      cap_data <= arr_data;
      commits  <= commits + 1;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cyc == 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int i);
    return cap_data[i*16 +: 16];
  endfunction

  // called at a negedge; one rising edge samples the write
  task automatic wr(input logic [15:0] a, input logic [15:0] d,
                    input bit c = 1, input bit w = 1, input bit o = 0);
    cs = c; we = w; oe = o; addr = a; data = d;
    @(negedge clk);
    cs = 0; we = 0; oe = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [15:0] ad(input int pg, input int w);
    return 16'((pg << 7) | w);
  endfunction

  task automatic t_reset();
    chk(busy == 0, "R10 reset busy", 64'(busy), 0);
    chk(arr_we == 0, "R5 reset arr_we", 64'(arr_we), 0);
  endtask

  task automatic t_pwrup();
    wr(ad(1, 0), 16'h1234);
    chk(busy == 0, "R7 write before power-on delay", 64'(busy), 0);
    idle(U + 5);
    chk(busy == 0 && commits == 0, "R7 no commit", 64'(commits), 0);
  endtask

  task automatic t_basic();
    int n, c0;
    c0 = commits;
    wr(ad(3, 5), 16'hA005);
    chk(busy == 1, "R10 busy after first load", 64'(busy), 1);
    wr(ad(3, 127), 16'hA07F);
    wr(ad(3, 0), 16'hA000);
    wr(ad(3, 5), 16'hB005);
    busy_len(n);
    chk(n == W + P, "R5 busy length", 64'(n), 64'(W + P));
    chk(commits == c0 + 1, "R5 single commit strobe", 64'(commits - c0), 1);
    chk(cap_page == 3, "R1 page", 64'(cap_page), 3);
    chk(word(0) == 16'hA000, "R1 word0", 64'(word(0)), 64'hA000);
    chk(word(127) == 16'hA07F, "R2 word127", 64'(word(127)), 64'hA07F);
    chk(word(5) == 16'hB005, "R2 last value wins", 64'(word(5)), 64'hB005);
    chk(word(1) == 16'hFFFF, "R4 word1 erased", 64'(word(1)), 64'hFFFF);
    chk(word(64) == 16'hFFFF, "R4 word64 erased", 64'(word(64)), 64'hFFFF);
  endtask

  task automatic t_inhibit();
    wr(ad(4, 1), 16'h0001, 1, 1, 1);
    chk(busy == 0, "R6 oe high blocks", 64'(busy), 0);
    wr(ad(4, 1), 16'h0001, 0, 1, 0);
    chk(busy == 0, "R6 cs low blocks", 64'(busy), 0);
    wr(ad(4, 1), 16'h0001, 1, 0, 0);
    chk(busy == 0, "R6 we low blocks", 64'(busy), 0);
  endtask

  task automatic t_restart();
    int n;
    wr(ad(5, 10), 16'h5A0A);
    idle(W - 2);
    wr(ad(5, 11), 16'h5A0B);
    busy_len(n);
    chk(n == W + P, "R3 window restarted", 64'(n), 64'(W + P));
    chk(word(10) == 16'h5A0A && word(11) == 16'h5A0B, "R3 both words",
        64'({word(10), word(11)}), 64'h5A0A5A0B);
  endtask

  task automatic t_foreign();
    int n;
    wr(ad(7, 1), 16'h7001);
    idle(3);
    wr(ad(8, 2), 16'h8002);
    busy_len(n);
    chk(n + 4 == W + P, "R8 foreign does not restart", 64'(n + 4), 64'(W + P));
    chk(cap_page == 7, "R8 page kept", 64'(cap_page), 7);
    chk(word(2) == 16'hFFFF, "R8 foreign data dropped", 64'(word(2)), 64'hFFFF);
  endtask

  task automatic t_prog_ignore();
    int n;
    wr(ad(2, 0), 16'h1111);
    idle(W + 3);
    wr(ad(2, 9), 16'h2222);
    wr(ad(9, 0), 16'h3333);
    busy_len(n);
    chk(n + W + 5 == W + P, "R9 busy unchanged", 64'(n + W + 5), 64'(W + P));
    chk(cap_page == 2, "R9 page", 64'(cap_page), 2);
    chk(word(9) == 16'hFFFF, "R9 late word dropped", 64'(word(9)), 64'hFFFF);
    chk(word(0) == 16'h1111, "R9 early word kept", 64'(word(0)), 64'h1111);
    idle(2);
    chk(busy == 0, "R9 no new load", 64'(busy), 0);
  endtask

  task automatic t_mask_clear();
    int n;
    for (int i = 0; i < 4; i++) wr(ad(4, i), 16'(16'h4400 + i));
    busy_len(n);
    chk(word(3) == 16'h4403, "R1 first load", 64'(word(3)), 64'h4403);
    wr(ad(4, 2), 16'h4E02);
    busy_len(n);
    chk(word(0) == 16'hFFFF, "R11 mask cleared w0", 64'(word(0)), 64'hFFFF);
    chk(word(3) == 16'hFFFF, "R11 mask cleared w3", 64'(word(3)), 64'hFFFF);
    chk(word(2) == 16'h4E02, "R11 new word", 64'(word(2)), 64'h4E02);
  endtask

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_pwrup();
    t_basic();
    t_inhibit();
    t_restart();
    t_foreign();
    t_prog_ignore();
    t_mask_clear();
    finish_run();
  end
endmodule